// File: doc/BRIEF.md
# Nesting Interrupt Enable and Trap Sequencer

This block decides when a small accumulator processor may be interrupted, and it carries out the entry into a handler. A plain enable flag is replaced by a saturating level that runs from 0 up to a top value of 2. An enable instruction raises the level by one and a disable instruction lowers it by one. External requests are accepted only while the level sits at the top. Code that already runs with interrupts enabled can therefore issue one disable, do a short critical section, and issue one enable to reopen. Code that started with interrupts disabled stays disabled after the same pair.

A trap is accepted whatever the level is. An interrupt is accepted only when the level is at the top. Either one starts a fixed three-cycle entry. In the first cycle the level is lowered once. In the second cycle a stack push is requested, carrying the program counter captured at acceptance. In the third cycle a program-counter load to the vector address is requested.

The block also tracks a halted state. A halt instruction sets it. A resume strobe clears it. An accepted interrupt or trap also clears it. While halted, every cycle counts as an instruction boundary, so a pending request can wake the processor. The stack memory and the instruction decoder are outside this block.

Top module: `irq_nest_seq`

## Requirements
- R1: After reset the enable level is 0, `halted_o` is 0, and `push_o` and `pc_load_o` are both 0.
- R2: On an effective boundary with no acceptance, `ei_i` alone raises the enable level by one and `di_i` alone lowers it by one. Both together leave it unchanged. An effective boundary is a cycle in which `boundary_i` is 1 or `halted_o` is 1.
- R3: The enable level saturates. Enable at 2 leaves it at 2, and disable at 0 leaves it at 0.
- R4: `irq_i` is accepted only on an effective boundary while the entry sequencer is idle and the enable level equals 2. At any other time it has no effect.
- R5: `trap_i` is accepted on any effective boundary while the sequencer is idle, whatever the enable level.
- R6: If a request is accepted in cycle t, then `push_o` is 1 in cycle t+2 with `push_data_o` equal to the `pc_i` value of cycle t. `pc_load_o` is 1 in cycle t+3 with `pc_load_addr_o` equal to 2. Neither output is 1 in any other cycle.
- R7: Each accepted entry lowers the enable level exactly once, with saturation at 0.
- R8: From the cycle after acceptance through the load cycle, `irq_i`, `trap_i`, `ei_i`, `di_i` and `halt_i` have no effect.
- R9: `halt_i` on an effective boundary with no acceptance sets `halted_o` from the next cycle. `resume_i` clears it in the next cycle and starts no entry. `resume_i` takes priority over `halt_i`.
- R10: A request accepted while halted clears `halted_o` in the next cycle and runs the normal entry sequence.
- R11: On a boundary where a request is accepted, `ei_i`, `di_i` and `halt_i` of that same cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| boundary_i | input | 1 | Marks the last cycle of an instruction |
| ei_i | input | 1 | Enable instruction strobe |
| di_i | input | 1 | Disable instruction strobe |
| irq_i | input | 1 | External interrupt request (level) |
| trap_i | input | 1 | Trap request |
| halt_i | input | 1 | Halt instruction strobe |
| resume_i | input | 1 | Continue after a halt |
| pc_i | input | PC_W | Current program counter |
| push_o | output | 1 | Stack push request |
| push_data_o | output | PC_W | Value to push (captured PC) |
| pc_load_o | output | 1 | Program counter load request |
| pc_load_addr_o | output | PC_W | Address to load (vector) |
| halted_o | output | 1 | Processor is halted |

## Verification
The bench builds the block with `PC_W` set to 8 and keeps the vector at 2 and the top enable level at 2. The narrow counter makes random PCs that are all zeros, all ones, or equal to the vector value common, so a wrong capture or a swap between the push and load fields shows up. Keeping the top level at 2 lets short random runs of enable and disable strobes reach both saturation ends many times. Halts followed by no boundaries test the wake path, where the halted state stands in for the boundary strobe.

// File: rtl/irq_nest_pkg.sv
// Shared types for the interrupt nesting sequencer.
// Assumes nothing beyond a two-bit state encoding.
package irq_nest_pkg;

    // Entry sequencer phases, in the order they run.
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_DEC  = 2'd1,
        SEQ_PUSH = 2'd2,
        SEQ_LOAD = 2'd3
    } seq_state_e;

endpackage

// File: rtl/ien_level.sv
// Saturating interrupt-enable level, 0..TOP.
// Assumes up and down are single-cycle strobes; both at once cancel out.
module ien_level #(
    parameter int TOP = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic up_i,
    input  logic dn_i,
    output logic at_top_o
);
    localparam int LVL_W = $clog2(TOP + 1);
    localparam logic [LVL_W-1:0] TOP_V = LVL_W'(TOP);

    logic [LVL_W-1:0] lvl_q;

    // Move the level one step, holding at both ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else if (up_i && !dn_i && (lvl_q != TOP_V)) begin
            lvl_q <= lvl_q + 1'b1;
        end else if (dn_i && !up_i && (lvl_q != '0)) begin
            lvl_q <= lvl_q - 1'b1;
        end
    end

    // Requests are allowed only at the top level.
    always_comb at_top_o = (lvl_q == TOP_V);

endmodule

// File: rtl/entry_seq.sv
// Three-phase handler entry: lower the level, push the captured PC, load the vector.
// Assumes take_i is raised only while idle_o is 1.
module entry_seq
    import irq_nest_pkg::*;
#(
    parameter int PC_W     = 12,
    parameter int VEC_ADDR = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take_i,
    input  logic [PC_W-1:0] pc_i,
    output logic            idle_o,
    output logic            dec_o,
    output logic            push_o,
    output logic [PC_W-1:0] push_data_o,
    output logic            load_o,
    output logic [PC_W-1:0] load_addr_o
);
    seq_state_e      st_q;
    logic [PC_W-1:0] pc_q;

    // Advance through the phases once a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= SEQ_IDLE;
        end else begin
            unique case (st_q)
                SEQ_IDLE: if (take_i) st_q <= SEQ_DEC;
                SEQ_DEC:  st_q <= SEQ_PUSH;
                SEQ_PUSH: st_q <= SEQ_LOAD;
                default:  st_q <= SEQ_IDLE;
            endcase
        end
    end

    // Keep the PC of the accepting cycle for the push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (take_i && (st_q == SEQ_IDLE)) begin
            pc_q <= pc_i;
        end
    end

    // Decode the phase into request strobes.
    always_comb begin
        idle_o      = (st_q == SEQ_IDLE);
        dec_o       = (st_q == SEQ_DEC);
        push_o      = (st_q == SEQ_PUSH);
        load_o      = (st_q == SEQ_LOAD);
        push_data_o = pc_q;
        load_addr_o = PC_W'(VEC_ADDR);
    end

endmodule

// File: rtl/halt_track.sv
// Halted flag with clear taking priority over set.
// Assumes set and clear are already qualified by the caller.
module halt_track (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic halted_o
);
    logic halt_q;

    // Hold the halted state between halt and wake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_q <= 1'b0;
        end else if (clr_i) begin
            halt_q <= 1'b0;
        end else if (set_i) begin
            halt_q <= 1'b1;
        end
    end

    // Expose the flag.
    always_comb halted_o = halt_q;

endmodule

// File: rtl/irq_nest_seq.sv
// Top: nesting interrupt enable, trap entry and halt tracking.
// Assumes the decoder gives instruction strobes only together with boundary_i.
module irq_nest_seq #(
    parameter int PC_W     = 12,
    parameter int VEC_ADDR = 2,
    parameter int EN_TOP   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            boundary_i,
    input  logic            ei_i,
    input  logic            di_i,
    input  logic            irq_i,
    input  logic            trap_i,
    input  logic            halt_i,
    input  logic            resume_i,
    input  logic [PC_W-1:0] pc_i,
    output logic            push_o,
    output logic [PC_W-1:0] push_data_o,
    output logic            pc_load_o,
    output logic [PC_W-1:0] pc_load_addr_o,
    output logic            halted_o
);
    logic at_top, seq_idle, seq_dec;
    logic eff_bnd, take, open_bnd;
    logic lvl_up, lvl_dn, halt_set, halt_clr;

    // Decide acceptance and qualify the instruction strobes.
    always_comb begin
        eff_bnd  = boundary_i | halted_o;
        take     = seq_idle && eff_bnd && (trap_i || (irq_i && at_top));
        open_bnd = seq_idle && eff_bnd && !take;
        lvl_up   = open_bnd && ei_i;
        lvl_dn   = seq_dec || (open_bnd && di_i);
        halt_set = open_bnd && halt_i;
        halt_clr = take || resume_i;
    end

    ien_level #(.TOP(EN_TOP)) u_level (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_i     (lvl_up),
        .dn_i     (lvl_dn),
        .at_top_o (at_top)
    );

    entry_seq #(.PC_W(PC_W), .VEC_ADDR(VEC_ADDR)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_i      (take),
        .pc_i        (pc_i),
        .idle_o      (seq_idle),
        .dec_o       (seq_dec),
        .push_o      (push_o),
        .push_data_o (push_data_o),
        .load_o      (pc_load_o),
        .load_addr_o (pc_load_addr_o)
    );

    halt_track u_halt (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (halt_set),
        .clr_i    (halt_clr),
        .halted_o (halted_o)
    );

endmodule

// File: rtl/irq_nest_chk.sv
// Protocol checks on the sequencer ports, bound into the top.
// Assumes rst_n is synchronous and active low.
module irq_nest_chk #(
    parameter int PC_W     = 12,
    parameter int VEC_ADDR = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            trap_i,
    input logic            resume_i,
    input logic [PC_W-1:0] pc_i,
    input logic            push_o,
    input logic [PC_W-1:0] push_data_o,
    input logic            pc_load_o,
    input logic [PC_W-1:0] pc_load_addr_o,
    input logic            halted_o
);
    p_push_then_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |=> pc_load_o);
    p_vector_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |-> (pc_load_addr_o == PC_W'(VEC_ADDR)));
    p_push_pc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> (push_data_o == $past(pc_i, 2)));
    p_single_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |=> !push_o);
    p_no_push_after_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |=> (!push_o && !pc_load_o));
    p_resume_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_o && resume_i) |=> !halted_o);
    p_trap_wakes_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_o && trap_i) |=> !halted_o);
endmodule

bind irq_nest_seq irq_nest_chk #(.PC_W(PC_W), .VEC_ADDR(VEC_ADDR)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .trap_i         (trap_i),
    .resume_i       (resume_i),
    .pc_i           (pc_i),
    .push_o         (push_o),
    .push_data_o    (push_data_o),
    .pc_load_o      (pc_load_o),
    .pc_load_addr_o (pc_load_addr_o),
    .halted_o       (halted_o)
);

// File: tb/irq_nest_seq_bench.sv
// Self-checking bench: directed corners plus seeded random stimulus against a bench model.
module irq_nest_seq_bench;
    localparam int PC_W = 8;
    localparam int VEC  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bnd = 1'b0, ei = 1'b0, di = 1'b0, irq = 1'b0, trap = 1'b0, hlt = 1'b0, res = 1'b0;
    logic [PC_W-1:0] pc = '0;
    logic push, load, halted;
    logic [PC_W-1:0] push_data, load_addr;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;

    // Bench model state.
    int m_lvl = 0;
    bit m_halt = 1'b0;
    int m_st = 0;
    logic [PC_W-1:0] m_pc = '0;

    always #2 clk = ~clk;

    irq_nest_seq #(.PC_W(PC_W), .VEC_ADDR(VEC), .EN_TOP(2)) u_irq_nest_seq (
        .clk(clk), .rst_n(rst_n), .boundary_i(bnd), .ei_i(ei), .di_i(di),
        .irq_i(irq), .trap_i(trap), .halt_i(hlt), .resume_i(res), .pc_i(pc),
        .push_o(push), .push_data_o(push_data), .pc_load_o(load),
        .pc_load_addr_o(load_addr), .halted_o(halted)
    );

    function automatic int sat_up(int v);
        return (v < 2) ? v + 1 : v;
    endfunction

    function automatic int sat_dn(int v);
        return (v > 0) ? v - 1 : v;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // One cycle: check outputs against the model, drive inputs, advance the model.
    task automatic tick(string tag, bit b, bit e, bit d, bit q, bit t, bit h, bit r,
                        logic [PC_W-1:0] p);
        bit eff, take, open;
        @(negedge clk);
        check(tag, "push", int'(push), int'(m_st == 2));
        if (m_st == 2) check(tag, "push_data", int'(push_data), int'(m_pc));
        check(tag, "load", int'(load), int'(m_st == 3));
        if (m_st == 3) check(tag, "load_addr", int'(load_addr), VEC);
        check(tag, "halted", int'(halted), int'(m_halt));
        bnd = b; ei = e; di = d; irq = q; trap = t; hlt = h; res = r; pc = p;
        eff  = b || m_halt;
        take = (m_st == 0) && eff && (t || (q && m_lvl == 2));
        open = (m_st == 0) && eff && !take;
        if (m_st == 1) m_lvl = sat_dn(m_lvl);
        else if (open && e && !d) m_lvl = sat_up(m_lvl);
        else if (open && d && !e) m_lvl = sat_dn(m_lvl);
        if (take || r) m_halt = 1'b0;
        else if (open && h) m_halt = 1'b1;
        if (take) begin
            m_pc = p;
            m_st = 1;
        end else if (m_st != 0) begin
            m_st = (m_st == 3) ? 0 : m_st + 1;
        end
    endtask

    task automatic idle(string tag, int n);
        for (int i = 0; i < n; i++) tick(tag, 0, 0, 0, 0, 0, 0, 0, 8'h00);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=100000", cyc);
            finish_up();
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state; the level at 0 also shows as an irq being refused.
        idle("R1", 1);
        tick("R1", 1, 0, 0, 1, 0, 0, 0, 8'h11);
        idle("R1", 4);
        // R4: irq without a boundary is ignored even at the top level.
        tick("R2", 1, 1, 0, 0, 0, 0, 0, 8'h00);
        tick("R2", 1, 1, 0, 0, 0, 0, 0, 8'h00);
        tick("R4", 0, 0, 0, 1, 0, 0, 0, 8'h33);
        idle("R4", 4);
        // R6: accepted irq pushes the captured PC, then loads the vector.
        tick("R6", 1, 0, 0, 1, 0, 0, 0, 8'hA5);
        idle("R6", 4);
        // R7: one entry lowered the level to 1, so a new irq is refused.
        tick("R7", 1, 0, 0, 1, 0, 0, 0, 8'h44);
        idle("R7", 4);
        // R3: enable saturates at 2; a single disable then leaves 1 and refuses.
        tick("R3", 1, 1, 0, 0, 0, 0, 0, 8'h00);
        tick("R3", 1, 1, 0, 0, 0, 0, 0, 8'h00);
        tick("R3", 1, 1, 0, 0, 0, 0, 0, 8'h00);
        tick("R3", 1, 0, 1, 0, 0, 0, 0, 8'h00);
        tick("R3", 1, 0, 0, 1, 0, 0, 0, 8'h55);
        idle("R3", 4);
        // R3: disable saturates at 0; two enables then reach the top.
        for (int i = 0; i < 4; i++) tick("R3", 1, 0, 1, 0, 0, 0, 0, 8'h00);
        tick("R2", 1, 1, 1, 0, 0, 0, 0, 8'h00);
        tick("R3", 1, 1, 0, 0, 0, 0, 0, 8'h00);
        tick("R3", 1, 1, 0, 0, 0, 0, 0, 8'h00);
        tick("R3", 1, 0, 0, 1, 0, 0, 0, 8'hFF);
        // R8: strobes during the entry have no effect.
        tick("R8", 1, 1, 0, 1, 1, 1, 0, 8'h01);
        tick("R8", 1, 1, 0, 1, 1, 1, 0, 8'h02);
        tick("R8", 1, 0, 1, 1, 1, 1, 0, 8'h03);
        idle("R8", 3);
        // R5: trap at any level, including 0 after repeated entries.
        tick("R5", 1, 0, 0, 0, 1, 0, 0, 8'h00);
        idle("R5", 4);
        tick("R5", 1, 0, 0, 0, 1, 0, 0, 8'h7E);
        idle("R5", 4);
        // R9: halt, stay halted without boundaries, resume without entry.
        tick("R9", 1, 0, 0, 0, 0, 1, 0, 8'h00);
        idle("R9", 3);
        tick("R9", 0, 0, 0, 0, 0, 1, 1, 8'h00);
        idle("R9", 4);
        // R10: irq while halted at the top level wakes and enters.
        tick("R10", 1, 1, 0, 0, 0, 0, 0, 8'h00);
        tick("R10", 1, 1, 0, 0, 0, 0, 0, 8'h00);
        tick("R10", 1, 0, 0, 0, 0, 1, 0, 8'h00);
        idle("R10", 2);
        tick("R10", 0, 0, 0, 1, 0, 0, 0, 8'h9C);
        idle("R10", 4);
        // R11: on the accepting boundary, ei and halt are dropped.
        tick("R11", 1, 1, 0, 0, 1, 1, 0, 8'h66);
        idle("R11", 4);
        tick("R11", 1, 0, 0, 1, 0, 0, 0, 8'h00);
        idle("R11", 4);
        // Random mix over all requirements.
        for (int i = 0; i < 4000; i++) begin
            tick("R4", ($urandom % 2) == 0, ($urandom % 5) == 0, ($urandom % 7) == 0,
                 ($urandom % 3) == 0, ($urandom % 20) == 0, ($urandom % 25) == 0,
                 ($urandom % 12) == 0, PC_W'($urandom));
        end
        idle("R6", 4);
        finish_up();
    end
endmodule